// File: doc/BRIEF.md
# Timing-Speculation Pipeline Stage with Error-Rate Supply Control

This block is a single pipeline register stage that tolerates late-arriving data. Each capture of the data word into the main register is followed by a second, later look at the same logic path. If the later sample disagrees with what the main register took, or if a metastability sensor reports that the main output settled near mid-rail, the stage treats this as a timing error. It overwrites the main register with the later sample and raises a one-cycle stall so that upstream logic holds its next word. The recovered word is presented downstream during that stall cycle, so no external rollback is needed.

Detected errors also drive a closed-loop controller that owns a digital supply-voltage code. The controller counts errors over a fixed window of clock cycles. A nearly error-free window shows that the logic finishes with time to spare, so the code steps down by one. A window with many errors shows that the clock period is being violated, so the code steps up by one. Counts between the two thresholds leave the code where it is. A metastable check is routed through two registered stages to a sticky panic output. While panic is high, the code is pinned at its maximum.

Top module: `tsd_ctrl`

## Requirements
- R1: After synchronous reset, `q` is 0, `stall` and `panic` are 0, and `vcode` equals VC_MAX.
- R2: On an edge with `cap_en` high and no error detected, `q` takes the value of `d_in` and a check becomes pending.
- R3: On an edge with a pending check, `late_en` high and `d_late` different from `q`, `q` is replaced by `d_late`. `stall` is high for the following cycle, and a capture requested on that same edge is discarded.
- R4: A late sample that matches `q` with `meta_in` low, or any late sample with no pending check, causes no error. `q` stays unchanged and `stall` stays low.
- R5: `meta_in` high on an edge with a pending check and `late_en` high counts as an error even when `d_late` equals `q`. It raises `stall` and is counted by the controller.
- R6: `stall` is never high on two consecutive cycles.
- R7: A window closes on every WIN_LEN-th clock edge after reset, and it counts the errors detected on its own edges. A total of at most LO_THR lowers `vcode` by 1, saturating at VC_MIN.
- R8: A window total of at least HI_THR raises `vcode` by 1, saturating at VC_MAX.
- R9: A window total strictly between LO_THR and HI_THR leaves `vcode` unchanged.
- R10: A metastable check (R5) sets `panic` on the clock edge after the one that raises `stall`. `panic` then stays high until reset.
- R11: On every edge that starts with `panic` high, `vcode` is set to VC_MAX.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_en | input | 1 | Main capture of `d_in` on this edge |
| d_in | input | DATA_W | Data word at the normal capture edge |
| late_en | input | 1 | Late sample of the pending capture is valid on this edge |
| d_late | input | DATA_W | Late (settled) value of the same logic path |
| meta_in | input | 1 | Metastability sensor flag for the pending capture |
| q | output | DATA_W | Registered stage output, recovered on error |
| stall | output | 1 | One-cycle hold request after a detected error |
| panic | output | 1 | Sticky panic after a metastable check |
| vcode | output | VC_W | Digital supply-voltage code |

## Verification
A stuck or stale pending flag shows at the ports within one cycle. It appears as a stall on a late sample that had no capture to check, or as a missing stall after a real mismatch. Corrupt error-counter state stays hidden until the window closes, so it shows on `vcode` up to WIN_LEN cycles later. It is caught by comparing `vcode` on every cycle across windows whose error totals fall below, on, between and above the thresholds. A panic chain of the wrong depth moves the rise of `panic`, and the jump of `vcode` to its maximum, by a cycle.

// File: rtl/tsd_pkg.sv
`timescale 1ns/1ps
package tsd_pkg;

    // Outcome of one late-sample comparison
    typedef struct packed {
        logic hit;   // timing error detected (mismatch or metastable)
        logic meta;  // the error came with the metastability flag
    } chk_ev_t;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_DOWN = 2'd1,
        DIR_UP   = 2'd2
    } rate_dir_t;

    // Classify a window error total against the two thresholds
    function automatic rate_dir_t judge_rate(int unsigned cnt,
                                             int unsigned lo,
                                             int unsigned hi);
        if (cnt <= lo)      return DIR_DOWN;
        else if (cnt >= hi) return DIR_UP;
        else                return DIR_HOLD;
    endfunction

    // One saturating step of the supply code
    function automatic int unsigned sat_move(int unsigned cur,
                                             rate_dir_t dir,
                                             int unsigned lo,
                                             int unsigned hi);
        int unsigned nxt;
        nxt = cur;
        case (dir)
            DIR_DOWN: nxt = (cur > lo) ? cur - 1 : lo;
            DIR_UP:   nxt = (cur < hi) ? cur + 1 : hi;
            default:  nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/tsd_shadow_stage.sv
`timescale 1ns/1ps
module tsd_shadow_stage
    import tsd_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] d_in,
    input  logic              late_en,
    input  logic [DATA_W-1:0] d_late,
    input  logic              meta_in,
    output logic [DATA_W-1:0] q,
    output logic              stall,
    output chk_ev_t           ev
);

    logic [DATA_W-1:0] main_q;
    logic              pend_q;
    logic              stall_q;
    logic [DATA_W-1:0] bit_diff;
    logic              word_diff;
    logic              check_now;

    // Per-bit comparison of the main register against the late sample
    for (genvar b = 0; b < DATA_W; b++) begin : g_cmp
        assign bit_diff[b] = main_q[b] ^ d_late[b];
    end

    assign word_diff = |bit_diff;
    assign check_now = pend_q & late_en;

    always_comb begin
        ev.hit  = check_now & (word_diff | meta_in);
        ev.meta = check_now & meta_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            main_q  <= '0;
            pend_q  <= 1'b0;
            stall_q <= 1'b0;
        end else begin
            stall_q <= ev.hit;
            if (ev.hit) begin
                // recovery: the late value wins, any new capture is dropped
                main_q <= d_late;
                pend_q <= 1'b0;
            end else if (cap_en) begin
                main_q <= d_in;
                pend_q <= 1'b1;
            end else if (late_en) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign q     = main_q;
    assign stall = stall_q;

endmodule

// File: rtl/tsd_panic_chain.sv
`timescale 1ns/1ps
module tsd_panic_chain #(
    parameter int N_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic meta_evt,
    output logic panic
);

    localparam int PW = N_STAGES - 1;

    logic [PW-1:0] pipe_q;
    logic          sticky_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q   <= '0;
            sticky_q <= 1'b0;
        end else begin
            pipe_q[0] <= meta_evt;
            for (int i = 1; i < PW; i++) begin
                pipe_q[i] <= pipe_q[i-1];
            end
            sticky_q <= sticky_q | pipe_q[PW-1];
        end
    end

    assign panic = sticky_q;

endmodule

// File: rtl/tsd_rate_ctrl.sv
`timescale 1ns/1ps
module tsd_rate_ctrl
    import tsd_pkg::*;
#(
    parameter int WIN_LEN = 16,
    parameter int LO_THR  = 1,
    parameter int HI_THR  = 4,
    parameter int VC_W    = 4,
    parameter int VC_MIN  = 0,
    parameter int VC_MAX  = 15
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            err_evt,
    input  logic            force_max,
    output logic [VC_W-1:0] vcode
);

    localparam int WCW = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
    localparam int ECW = $clog2(WIN_LEN + 1);

    logic [WCW-1:0]  wcnt_q;
    logic [ECW-1:0]  ecnt_q;
    logic [ECW-1:0]  tally;
    logic            win_end;
    rate_dir_t       dir;
    logic [VC_W-1:0] code_next;
    logic [VC_W-1:0] code_q;

    assign win_end = (wcnt_q == WCW'(WIN_LEN - 1));
    assign tally   = ecnt_q + ECW'(err_evt);

    always_comb begin
        dir       = judge_rate(32'(tally), LO_THR, HI_THR);
        code_next = VC_W'(sat_move(32'(code_q), dir, VC_MIN, VC_MAX));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt_q <= '0;
            ecnt_q <= '0;
            code_q <= VC_W'(VC_MAX);
        end else begin
            if (win_end) begin
                wcnt_q <= '0;
                ecnt_q <= '0;
            end else begin
                wcnt_q <= wcnt_q + 1'b1;
                ecnt_q <= tally;
            end
            if (force_max)    code_q <= VC_W'(VC_MAX);
            else if (win_end) code_q <= code_next;
        end
    end

    assign vcode = code_q;

endmodule

// File: rtl/tsd_ctrl.sv
`timescale 1ns/1ps
module tsd_ctrl
    import tsd_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int WIN_LEN      = 16,
    parameter int LO_THR       = 1,
    parameter int HI_THR       = 4,
    parameter int VC_W         = 4,
    parameter int VC_MIN       = 0,
    parameter int VC_MAX       = 15,
    parameter int PANIC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] d_in,
    input  logic              late_en,
    input  logic [DATA_W-1:0] d_late,
    input  logic              meta_in,
    output logic [DATA_W-1:0] q,
    output logic              stall,
    output logic              panic,
    output logic [VC_W-1:0]   vcode
);

    chk_ev_t ev;
    logic    panic_w;

    tsd_shadow_stage #(.DATA_W(DATA_W)) u_stage (
        .clk     (clk),
        .rst     (rst),
        .cap_en  (cap_en),
        .d_in    (d_in),
        .late_en (late_en),
        .d_late  (d_late),
        .meta_in (meta_in),
        .q       (q),
        .stall   (stall),
        .ev      (ev)
    );

    tsd_panic_chain #(.N_STAGES(PANIC_STAGES)) u_panic (
        .clk      (clk),
        .rst      (rst),
        .meta_evt (ev.meta),
        .panic    (panic_w)
    );

    tsd_rate_ctrl #(
        .WIN_LEN (WIN_LEN),
        .LO_THR  (LO_THR),
        .HI_THR  (HI_THR),
        .VC_W    (VC_W),
        .VC_MIN  (VC_MIN),
        .VC_MAX  (VC_MAX)
    ) u_rate (
        .clk       (clk),
        .rst       (rst),
        .err_evt   (ev.hit),
        .force_max (panic_w),
        .vcode     (vcode)
    );

    assign panic = panic_w;

endmodule

// File: rtl/tsd_ctrl_chk.sv
`timescale 1ns/1ps
module tsd_ctrl_chk #(
    parameter int DATA_W = 8,
    parameter int VC_W   = 4,
    parameter int VC_MIN = 0,
    parameter int VC_MAX = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              late_en,
    input logic [DATA_W-1:0] d_late,
    input logic [DATA_W-1:0] q,
    input logic              stall,
    input logic              panic,
    input logic [VC_W-1:0]   vcode
);

    // R3: during the stall cycle the output holds the late sample
    assert_restore_R3: assert property (@(posedge clk) disable iff (rst)
        stall |-> (q == $past(d_late)));

    // R4: without a late sample there is never a stall next cycle
    assert_no_late_no_stall_R4: assert property (@(posedge clk) disable iff (rst)
        !late_en |=> !stall);

    // R6: stall lasts a single cycle
    assert_stall_single_R6: assert property (@(posedge clk) disable iff (rst)
        stall |=> !stall);

    // R7 / R8: code stays in its legal range
    assert_vcode_range_R8: assert property (@(posedge clk) disable iff (rst)
        (int'(vcode) >= VC_MIN) && (int'(vcode) <= VC_MAX));

    // R7 / R9: outside panic the code moves by at most one step
    assert_vcode_step_R7: assert property (@(posedge clk) disable iff (rst)
        (vcode != $past(vcode)) |-> (panic
            || (int'(vcode) == int'($past(vcode)) + 1)
            || (int'(vcode) + 1 == int'($past(vcode)))));

    // R10: panic is sticky
    assert_panic_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        panic |=> panic);

    // R11: panic pins the code at its maximum
    assert_panic_max_R11: assert property (@(posedge clk) disable iff (rst)
        panic |=> (int'(vcode) == VC_MAX));

endmodule

bind tsd_ctrl tsd_ctrl_chk #(
    .DATA_W (DATA_W),
    .VC_W   (VC_W),
    .VC_MIN (VC_MIN),
    .VC_MAX (VC_MAX)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .late_en (late_en),
    .d_late  (d_late),
    .q       (q),
    .stall   (stall),
    .panic   (panic),
    .vcode   (vcode)
);

// File: tb/tb_tsd_ctrl.sv
`timescale 1ns/1ps
module tb_tsd_ctrl;

    localparam int DW   = 8;
    localparam int WL   = 8;
    localparam int LO   = 1;
    localparam int HI   = 3;
    localparam int VW   = 3;
    localparam int VMIN = 1;
    localparam int VMAX = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          cap_en, late_en, meta_in;
    logic [DW-1:0] d_in, d_late;
    logic [DW-1:0] q;
    logic          stall, panic;
    logic [VW-1:0] vcode;

    always #10 clk = ~clk;   // 50 MHz

    tsd_ctrl #(
        .DATA_W(DW), .WIN_LEN(WL), .LO_THR(LO), .HI_THR(HI),
        .VC_W(VW), .VC_MIN(VMIN), .VC_MAX(VMAX), .PANIC_STAGES(2)
    ) dut (
        .clk(clk), .rst(rst), .cap_en(cap_en), .d_in(d_in),
        .late_en(late_en), .d_late(d_late), .meta_in(meta_in),
        .q(q), .stall(stall), .panic(panic), .vcode(vcode)
    );

    int checks = 0;
    int errors = 0;

    // expected state, derived from the requirements
    int m_q, m_ecnt, m_edges, m_vcode;
    bit m_pend, m_stall, m_m1, m_panic;

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        check(tag, "q",     int'(q),     m_q);
        check(tag, "stall", int'(stall), int'(m_stall));
        check(tag, "panic", int'(panic), int'(m_panic));
        check(tag, "vcode", int'(vcode), m_vcode);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // one clock cycle: drive at negedge, expect after posedge, compare at negedge
    task automatic cyc(string tag, bit cap, int d, bit late, int dl, bit meta);
        bit err;
        int tally, nv;
        bit np;
        cap_en  = cap;
        d_in    = DW'(d);
        late_en = late;
        d_late  = DW'(dl);
        meta_in = meta;
        @(posedge clk);
        dl  = dl & ((1 << DW) - 1);
        d   = d & ((1 << DW) - 1);
        err = m_pend && late && ((dl != m_q) || meta);
        nv  = m_vcode;
        tally = m_ecnt + int'(err);
        if (m_panic) nv = VMAX;
        else if ((m_edges + 1) % WL == 0) begin
            if (tally <= LO)      nv = (m_vcode > VMIN) ? m_vcode - 1 : VMIN;
            else if (tally >= HI) nv = (m_vcode < VMAX) ? m_vcode + 1 : VMAX;
        end
        m_ecnt  = ((m_edges + 1) % WL == 0) ? 0 : tally;
        m_edges = m_edges + 1;
        m_vcode = nv;
        np      = m_panic | m_m1;
        m_m1    = err && meta;
        m_panic = np;
        m_stall = err;
        if (err) begin
            m_q = dl; m_pend = 1'b0;
        end else if (cap) begin
            m_q = d; m_pend = 1'b1;
        end else if (late) begin
            m_pend = 1'b0;
        end
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic idle(string tag, int n);
        for (int i = 0; i < n; i++) cyc(tag, 0, 0, 0, 0, 0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cap_en = 0; late_en = 0; meta_in = 0; d_in = '0; d_late = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_q = 0; m_ecnt = 0; m_edges = 0; m_vcode = VMAX;
        m_pend = 0; m_stall = 0; m_m1 = 0; m_panic = 0;
        compare_all("R1");
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        do_reset();

        // R7: error-free windows walk the code down and saturate at VMIN
        idle("R7", 6 * WL);
        check("R7", "vcode at min", int'(vcode), VMIN);

        // R2 / R4: every data value captured, then a matching late sample
        for (int v = 0; v < (1 << DW); v++) begin
            cyc("R2", 1, v, 0, 0, 0);
            check("R2", "captured", int'(q), v);
            cyc("R4", 0, 0, 1, v, 0);
            if (v % 16 == 5) begin
                // late sample with nothing pending: no effect
                cyc("R4", 0, 0, 1, ~v, 0);
                check("R4", "q unchanged", int'(q), v);
                check("R4", "no stall", int'(stall), 0);
            end
        end

        // R7 boundary, R9, R8, R3, R6
        do_reset();
        idle("R7", WL);                          // 0 errors: 6 -> 5
        cyc("R3", 1, 8'h11, 0, 0, 0);
        cyc("R3", 0, 0, 1, 8'hEE, 0);            // one error
        check("R3", "restored", int'(q), 8'hEE);
        check("R3", "stall", int'(stall), 1);
        idle("R6", 1);
        check("R6", "stall dropped", int'(stall), 0);
        idle("R7", WL - 3);                      // total 1 = LO: 5 -> 4
        check("R7", "down at LO", int'(vcode), 4);
        for (int w = 0; w < 3; w++) begin        // 2 errors per window
            for (int e = 0; e < 2; e++) begin
                cyc("R3", 1, 8'h30 + e, 0, 0, 0);
                cyc("R3", 0, 0, 1, 8'hC0 + w, 0);
            end
            idle("R9", WL - 4);
        end
        check("R9", "held", int'(vcode), 4);
        for (int w = 0; w < 3; w++) begin        // 3 errors per window
            for (int e = 0; e < 3; e++) begin
                cyc("R3", 1, 8'h40 + e, 0, 0, 0);
                cyc("R3", 1, 8'h99, 1, 8'hA0 + e, 0);  // capture dropped
                check("R3", "capture discarded", int'(q), 8'hA0 + e);
            end
            idle("R8", WL - 6);
        end
        check("R8", "saturated max", int'(vcode), VMAX);

        // R5 / R10 / R11
        do_reset();
        idle("R7", 3 * WL);                      // 6 -> 3
        cyc("R5", 1, 8'h5A, 0, 0, 0);
        cyc("R5", 0, 0, 1, 8'h5A, 1);            // matching data, metastable
        check("R5", "stall on meta", int'(stall), 1);
        check("R10", "no panic yet", int'(panic), 0);
        idle("R10", 1);
        check("R10", "panic set", int'(panic), 1);
        idle("R11", 1);
        check("R11", "vcode forced max", int'(vcode), VMAX);
        idle("R11", 2 * WL);
        check("R10", "panic sticky", int'(panic), 1);
        check("R11", "vcode still max", int'(vcode), VMAX);

        do_reset();
        check("R1", "panic cleared", int'(panic), 0);
        idle("R1", 2);

        finish_run();
    end

endmodule